// File: doc/BRIEF.md
# Serial Receive Queue with Idle Timeout

This block is the receive side of a classic byte-oriented serial controller. It sits between a character deserializer and the byte-wide data-register read port. Incoming characters are kept in a 16-entry first-in first-out queue. The block maintains the data-ready, overrun and break flags. It reports when the fill level reaches a programmable trigger point, and it flags a timeout when characters have sat unread for four character times.

When the queue is switched off, a single holding register takes its place and the trigger output follows data-ready. Interrupt prioritisation is left to a separate encoder, which consumes the status outputs directly. One character time is the bit period multiplied by the frame length, where the frame is 1 start bit, 5 to 8 data bits, an optional parity bit and 1 or 2 stop bits. The surrounding logic works out this value as a count of clock cycles and drives it on `char_cycles`.

Top module: `uart_rxq_top`

## Requirements
- R1: With the queue enabled and holding 16 bytes, a further received character is dropped, `stat_overrun` rises, and the stored bytes and `level` stay unchanged.
- R2: In queue mode `stat_trig` is high while `level` is at least the threshold chosen by `trig_sel`: 2'b00 selects 1, 2'b01 selects 4, 2'b10 selects 8, 2'b11 selects 14.
- R3: In queue mode a received character restarts an idle timer of 4×`char_cycles` clock cycles, and so does a read that leaves data behind. `stat_timeout` rises exactly 4×`char_cycles` clock edges after the restart edge, provided the queue is not empty at that point.
- R4: Any `rd_strobe` clears `stat_timeout`. A read of an empty queue returns 0x00 on `rd_data`.
- R5: A received character sets `stat_ready`. A read that removes the last byte clears both `stat_ready` and `stat_break`.
- R6: A pulse on `rx_flush` empties the queue, clears `stat_ready`, `stat_break` and `stat_timeout`, and stops the timer. Any change of `fifo_en` has the same effect.
- R7: A pulse on `rx_break` stores 0x00 as a character and sets both `stat_break` and `stat_ready`.
- R8: With `fifo_en` low, one holding register is used. A character received while `stat_ready` is set raises `stat_overrun` and replaces the held byte, and a read clears `stat_ready`.
- R9: A pulse on `lsr_rd` clears `stat_overrun` and `stat_break` and leaves the data and `stat_ready` untouched.
- R10: Bytes are read out in arrival order, and `rd_data` always shows the byte that a read in the current cycle returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Queue mode when high, holding-register mode when low |
| trig_sel | input | 2 | Trigger threshold code |
| rx_flush | input | 1 | Receive queue reset pulse |
| char_cycles | input | 16 | Clock cycles per character time |
| rx_valid | input | 1 | Received character strobe |
| rx_break | input | 1 | Line break detected strobe |
| rx_data | input | 8 | Received character |
| rd_strobe | input | 1 | Data register read |
| lsr_rd | input | 1 | Line status read (clears error flags) |
| rd_data | output | 8 | Byte returned by a read this cycle |
| level | output | 5 | Bytes held in the queue |
| stat_ready | output | 1 | Data ready |
| stat_trig | output | 1 | Trigger level reached |
| stat_overrun | output | 1 | Overrun occurred |
| stat_break | output | 1 | Break received |
| stat_timeout | output | 1 | Character timeout pending |

## Verification
Pointer or count corruption shows up at the ports the first time the queue is drained. `rd_data` then returns a byte out of order, or `level` disagrees with the number of bytes pushed, in the same cycle as the faulty read. A timer that is off by one is detected by sampling `stat_timeout` two edges before and exactly at its expected rise. Flag bookkeeping errors appear one edge after the stimulus that should set or clear the flag.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int unsigned RXQ_DATA_W = 8;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_code_e;

    typedef struct packed {
        logic                  valid;
        logic                  brk;
        logic [RXQ_DATA_W-1:0] data;
    } rx_evt_t;

    function automatic logic [4:0] trig_threshold(input logic [1:0] code);
        case (trig_code_e'(code))
            TRIG_ONE:      return 5'd1;
            TRIG_FOUR:     return 5'd4;
            TRIG_EIGHT:    return 5'd8;
            default:       return 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push && !clr) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
    parameter int unsigned CHAR_W = 16,
    localparam int unsigned TMR_W = CHAR_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              stop,
    input  logic [CHAR_W-1:0] char_cycles,
    output logic              expire
);
    logic [TMR_W-1:0] cnt;
    logic             running;
    logic [TMR_W-1:0] limit;

    assign limit  = {char_cycles, 2'b00};
    assign expire = running && (cnt == TMR_W'(1)) && !restart && !stop;

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (restart) begin
            cnt     <= limit;
            running <= (limit != '0);
        end else if (running) begin
            cnt <= cnt - 1'b1;
            if (cnt == TMR_W'(1)) running <= 1'b0;
        end
    end
endmodule

// File: rtl/rxq_status.sv
module rxq_status #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              fifo_mode,
    input  logic              rx_ev,
    input  logic              rx_brk,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              ovf,
    input  logic              emptied,
    input  logic              rd,
    input  logic              lsr_rd,
    input  logic              expire,
    input  logic              nonempty,
    output logic              ready,
    output logic              overrun,
    output logic              brk,
    output logic              timeout,
    output logic [DATA_W-1:0] hold
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ready   <= 1'b0;
            overrun <= 1'b0;
            brk     <= 1'b0;
            timeout <= 1'b0;
            hold    <= '0;
        end else begin
            // overrun: only an explicit status read clears it
            if (ovf)         overrun <= 1'b1;
            else if (lsr_rd) overrun <= 1'b0;

            if (clr) begin
                ready   <= 1'b0;
                brk     <= 1'b0;
                timeout <= 1'b0;
            end else begin
                if (rx_ev)                        ready <= 1'b1;
                else if (fifo_mode ? emptied : rd) ready <= 1'b0;

                if (rx_brk)                                   brk <= 1'b1;
                else if ((fifo_mode ? emptied : rd) || lsr_rd) brk <= 1'b0;

                if (rd)                        timeout <= 1'b0;
                else if (expire && nonempty)   timeout <= 1'b1;

                if (rx_ev && !fifo_mode) hold <= rx_byte;
            end
        end
    end
endmodule

// File: rtl/uart_rxq_top.sv
module uart_rxq_top
    import uart_rxq_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned CHAR_W = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic [1:0]        trig_sel,
    input  logic              rx_flush,
    input  logic [CHAR_W-1:0] char_cycles,
    input  logic              rx_valid,
    input  logic              rx_break,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rd_strobe,
    input  logic              lsr_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  level,
    output logic              stat_ready,
    output logic              stat_trig,
    output logic              stat_overrun,
    output logic              stat_break,
    output logic              stat_timeout
);
    rx_evt_t            ev;
    logic               en_q;
    logic               flush_all;
    logic               full, empty;
    logic               push, pop, ovf, emptied;
    logic [CNT_W-1:0]   count_nxt;
    logic               tmr_restart, tmr_stop, expire;
    logic [DATA_W-1:0]  head, hold;

    assign ev.valid = rx_valid | rx_break;
    assign ev.brk   = rx_break;
    assign ev.data  = rx_break ? '0 : rx_data;

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= fifo_en;
    end

    // a mode change flushes the queue like an explicit reset command
    assign flush_all = rx_flush | (fifo_en ^ en_q);
    assign full      = (level == CNT_W'(DEPTH));
    assign empty     = (level == '0);

    assign pop     = fifo_en && !flush_all && rd_strobe && !empty;
    assign push    = fifo_en && !flush_all && ev.valid && (!full || pop);
    assign emptied = pop && !push && (level == CNT_W'(1));

    always_comb begin
        if (flush_all)
            ovf = 1'b0;
        else if (fifo_en)
            ovf = ev.valid && full && !pop;
        else
            ovf = ev.valid && stat_ready && !rd_strobe;
    end

    always_comb begin
        count_nxt = level;
        if (push) count_nxt = count_nxt + 1'b1;
        if (pop)  count_nxt = count_nxt - 1'b1;
    end

    assign tmr_stop    = flush_all || (fifo_en && rd_strobe && count_nxt == '0);
    assign tmr_restart = fifo_en && !flush_all &&
                         (ev.valid || (rd_strobe && count_nxt != '0));

    rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (flush_all),
        .push  (push),
        .pop   (pop),
        .wdata (ev.data),
        .head  (head),
        .count (level)
    );

    rxq_idle_timer #(.CHAR_W(CHAR_W)) timer_i (
        .clk         (clk),
        .rst         (rst),
        .restart     (tmr_restart),
        .stop        (tmr_stop),
        .char_cycles (char_cycles),
        .expire      (expire)
    );

    rxq_status #(.DATA_W(DATA_W)) status_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (flush_all),
        .fifo_mode (fifo_en),
        .rx_ev     (ev.valid),
        .rx_brk    (ev.brk),
        .rx_byte   (ev.data),
        .ovf       (ovf),
        .emptied   (emptied),
        .rd        (rd_strobe),
        .lsr_rd    (lsr_rd),
        .expire    (expire),
        .nonempty  (!empty),
        .ready     (stat_ready),
        .overrun   (stat_overrun),
        .brk       (stat_break),
        .timeout   (stat_timeout),
        .hold      (hold)
    );

    always_comb begin
        if (!fifo_en)   rd_data = hold;
        else if (empty) rd_data = '0;
        else            rd_data = head;
    end

    assign stat_trig = fifo_en ? (level >= CNT_W'(trig_threshold(trig_sel)))
                               : stat_ready;
endmodule

// File: rtl/uart_rxq_checker.sv
module uart_rxq_checker #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_en,
    input logic             rx_valid,
    input logic             rx_break,
    input logic             rx_flush,
    input logic             rd_strobe,
    input logic [CNT_W-1:0] level,
    input logic             stat_ready,
    input logic             stat_break,
    input logic             stat_overrun,
    input logic             stat_timeout
);
    logic prev_en;
    always_ff @(posedge clk) begin
        if (rst) prev_en <= 1'b0;
        else     prev_en <= fifo_en;
    end

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
        level <= CNT_W'(DEPTH));

    p_full_keeps_r1: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && prev_en && rx_valid && level == CNT_W'(DEPTH) && !rd_strobe && !rx_flush)
        |=> (level == CNT_W'(DEPTH) && stat_overrun));

    p_timeout_has_data_r3: assert property (@(posedge clk) disable iff (rst)
        stat_timeout |-> level != '0);

    p_read_clears_timeout_r4: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |=> !stat_timeout);

    p_ready_with_data_r5: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && level != '0) |-> stat_ready);

    p_flush_clears_r6: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> (level == '0 && !stat_ready && !stat_break && !stat_timeout));

    p_break_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_break && !rx_flush && fifo_en == prev_en) |=> (stat_break && stat_ready));
endmodule

bind uart_rxq_top uart_rxq_checker #(.DEPTH(DEPTH)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .fifo_en      (fifo_en),
    .rx_valid     (rx_valid),
    .rx_break     (rx_break),
    .rx_flush     (rx_flush),
    .rd_strobe    (rd_strobe),
    .level        (level),
    .stat_ready   (stat_ready),
    .stat_break   (stat_break),
    .stat_overrun (stat_overrun),
    .stat_timeout (stat_timeout)
);

// File: tb/uart_rxq_top_tb_top.sv
module uart_rxq_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        fifo_en;
    logic [1:0]  trig_sel;
    logic        rx_flush;
    logic [15:0] char_cycles;
    logic        rx_valid;
    logic        rx_break;
    logic [7:0]  rx_data;
    logic        rd_strobe;
    logic        lsr_rd;
    logic [7:0]  rd_data;
    logic [4:0]  level;
    logic        stat_ready, stat_trig, stat_overrun, stat_break, stat_timeout;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rxq_top dut_i (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .trig_sel(trig_sel),
        .rx_flush(rx_flush), .char_cycles(char_cycles), .rx_valid(rx_valid),
        .rx_break(rx_break), .rx_data(rx_data), .rd_strobe(rd_strobe),
        .lsr_rd(lsr_rd), .rd_data(rd_data), .level(level),
        .stat_ready(stat_ready), .stat_trig(stat_trig),
        .stat_overrun(stat_overrun), .stat_break(stat_break),
        .stat_timeout(stat_timeout)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic send_break();
        @(negedge clk); rx_break = 1'b1;
        @(negedge clk); rx_break = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] b);
        @(negedge clk); rd_strobe = 1'b1; #1 b = rd_data;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic flush();
        @(negedge clk); rx_flush = 1'b1;
        @(negedge clk); rx_flush = 1'b0;
    endtask

    task automatic status_read();
        @(negedge clk); lsr_rd = 1'b1;
        @(negedge clk); lsr_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R5 reset ready", 16'(stat_ready), 16'd0);
        chk("R1 reset overrun", 16'(stat_overrun), 16'd0);
        chk("R7 reset break", 16'(stat_break), 16'd0);
        chk("R3 reset timeout", 16'(stat_timeout), 16'd0);
        chk("R10 reset level", 16'(level), 16'd0);
    endtask

    task automatic t_order_r10();
        logic [7:0] b;
        fifo_en = 1'b1; repeat (2) @(negedge clk);
        send(8'h11); send(8'h22); send(8'h33);
        chk("R10 level after 3", 16'(level), 16'd3);
        chk("R5 ready set", 16'(stat_ready), 16'd1);
        read_byte(b); chk("R10 first", 16'(b), 16'h11);
        read_byte(b); chk("R10 second", 16'(b), 16'h22);
        chk("R5 ready kept", 16'(stat_ready), 16'd1);
        read_byte(b); chk("R10 third", 16'(b), 16'h33);
        chk("R5 ready cleared on empty", 16'(stat_ready), 16'd0);
        read_byte(b); chk("R4 empty read zero", 16'(b), 16'h00);
    endtask

    task automatic t_trig_r2();
        flush(); trig_sel = 2'b01;
        for (int i = 0; i < 3; i++) send(8'(i));
        chk("R2 code01 below", 16'(stat_trig), 16'd0);
        send(8'h03);
        chk("R2 code01 at 4", 16'(stat_trig), 16'd1);
        flush(); trig_sel = 2'b11;
        chk("R6 flush level", 16'(level), 16'd0);
        chk("R6 flush ready", 16'(stat_ready), 16'd0);
        for (int i = 0; i < 13; i++) send(8'(i));
        chk("R2 code11 at 13", 16'(stat_trig), 16'd0);
        send(8'h0d);
        chk("R2 code11 at 14", 16'(stat_trig), 16'd1);
        trig_sel = 2'b10; #1;
        chk("R2 code10 at 14", 16'(stat_trig), 16'd1);
        flush(); trig_sel = 2'b10;
        for (int i = 0; i < 7; i++) send(8'(i));
        chk("R2 code10 at 7", 16'(stat_trig), 16'd0);
        flush(); trig_sel = 2'b00; #1;
        chk("R2 code00 empty", 16'(stat_trig), 16'd0);
        send(8'h55);
        chk("R2 code00 at 1", 16'(stat_trig), 16'd1);
    endtask

    task automatic t_overrun_r1();
        logic [7:0] b;
        flush();
        for (int i = 0; i < 16; i++) send(8'(8'h40 + i));
        chk("R1 full level", 16'(level), 16'd16);
        chk("R1 no overrun yet", 16'(stat_overrun), 16'd0);
        send(8'hEE);
        chk("R1 overrun set", 16'(stat_overrun), 16'd1);
        chk("R1 level kept", 16'(level), 16'd16);
        for (int i = 0; i < 16; i++) begin
            read_byte(b);
            chk("R1 contents kept", 16'(b), 16'(8'h40 + i));
        end
        chk("R1 overrun sticky", 16'(stat_overrun), 16'd1);
        status_read();
        chk("R9 overrun cleared", 16'(stat_overrun), 16'd0);
    endtask

    task automatic t_timeout_r3();
        logic [7:0] b;
        flush(); char_cycles = 16'd5;
        send(8'hA1);
        repeat (18) @(negedge clk);
        chk("R3 not yet at 18", 16'(stat_timeout), 16'd0);
        repeat (2) @(negedge clk);
        chk("R3 set at 20", 16'(stat_timeout), 16'd1);
        read_byte(b);
        chk("R4 read clears timeout", 16'(stat_timeout), 16'd0);
        repeat (30) @(negedge clk);
        chk("R3 no timeout when empty", 16'(stat_timeout), 16'd0);
        send(8'hB1); send(8'hB2);
        repeat (21) @(negedge clk);
        chk("R3 set with two", 16'(stat_timeout), 16'd1);
        read_byte(b);
        chk("R4 partial read clears", 16'(stat_timeout), 16'd0);
        repeat (18) @(negedge clk);
        chk("R3 restarted by read", 16'(stat_timeout), 16'd0);
        repeat (2) @(negedge clk);
        chk("R3 expires after read", 16'(stat_timeout), 16'd1);
        flush();
        chk("R6 flush clears timeout", 16'(stat_timeout), 16'd0);
    endtask

    task automatic t_break_r7();
        logic [7:0] b;
        flush();
        send_break();
        chk("R7 level", 16'(level), 16'd1);
        chk("R7 break", 16'(stat_break), 16'd1);
        chk("R7 ready", 16'(stat_ready), 16'd1);
        read_byte(b);
        chk("R7 null byte", 16'(b), 16'h00);
        chk("R5 break cleared on empty", 16'(stat_break), 16'd0);
        send_break();
        status_read();
        chk("R9 break cleared", 16'(stat_break), 16'd0);
        chk("R9 ready kept", 16'(stat_ready), 16'd1);
        chk("R9 level kept", 16'(level), 16'd1);
    endtask

    task automatic t_toggle_r6();
        send(8'h77);
        @(negedge clk); fifo_en = 1'b0;
        @(negedge clk);
        chk("R6 toggle empties", 16'(level), 16'd0);
        chk("R6 toggle ready", 16'(stat_ready), 16'd0);
    endtask

    task automatic t_hold_r8();
        logic [7:0] b;
        send(8'h5A);
        chk("R8 ready", 16'(stat_ready), 16'd1);
        chk("R8 trig follows ready", 16'(stat_trig), 16'd1);
        chk("R8 held byte", 16'(rd_data), 16'h5A);
        chk("R8 no overrun", 16'(stat_overrun), 16'd0);
        send(8'hA5);
        chk("R8 overrun", 16'(stat_overrun), 16'd1);
        chk("R8 replaced", 16'(rd_data), 16'hA5);
        chk("R8 queue unused", 16'(level), 16'd0);
        read_byte(b);
        chk("R8 read value", 16'(b), 16'hA5);
        chk("R8 ready cleared", 16'(stat_ready), 16'd0);
    endtask

    initial begin
        rst = 1'b1; fifo_en = 1'b0; trig_sel = 2'b00; rx_flush = 1'b0;
        char_cycles = 16'd5; rx_valid = 1'b0; rx_break = 1'b0; rx_data = '0;
        rd_strobe = 1'b0; lsr_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_order_r10();
        t_trig_r2();
        t_overrun_r1();
        t_timeout_r3();
        t_break_r7();
        t_toggle_r6();
        t_hold_r8();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule